// File: doc/BRIEF.md
# CPU-to-CSR Width Down-Converter

This block sits between a wide processor-side register port and a narrow control/status register bus. Each processor access (one word of `CPU_DATA_W` bits) is turned into a burst of `RATIO = CPU_DATA_W / CSR_DATA_W` single-cycle accesses on the narrow bus. The burst covers consecutive chunk addresses, and the least significant chunk goes first. For a write, the word is cut into chunks. For a read, the chunks returned by the bus are gathered back into one word. The word address `A` maps to the chunk addresses `A*RATIO + i`, so the narrow address is the wide address with `log2(RATIO)` index bits appended below it.

The chunks go out strictly in ascending order and a burst is never cut short, and both hold for narrow target registers too. This matters because registers behind the narrow bus snapshot their whole value on the chunk-0 read and commit on the last-chunk write. Narrow-bus accesses never stall and never fail. Read data on the narrow bus arrives one cycle after its strobe. `RATIO` must be a power of two of at least 2.

Top module: `csr_width_bridge`

## Requirements
- R1: After an access is accepted (cpuValid and cpuReady high at a clock edge), exactly RATIO strobe cycles follow, starting the next cycle, one per cycle, back to back, at csrAddr = {cpuAddr, i} for i = 0, 1, ..., RATIO-1 in that order.
- R2: On a write burst, csrWstb is high and csrWdata in the strobe cycle for chunk i equals cpuWdata[i*CSR_DATA_W +: CSR_DATA_W] of the accepted word. All RATIO writes are issued whatever the width of the target register.
- R3: On a read burst, csrRstb is high. The value on csrRdata one cycle after the chunk-i strobe is placed in bits [i*CSR_DATA_W +: CSR_DATA_W] of the returned word.
- R4: csrRstb and csrWstb are never high together, and both stay low whenever no burst is in progress.
- R5: cpuReady is high when idle and low from the cycle after acceptance until the response cycle. The response (cpuRvalid high for one cycle, cpuReady high again) comes RATIO+2 cycles after the accepting edge, for reads and writes alike.
- R6: During the response cycle of a read, cpuRdata holds the gathered word, so a CSR register with snapshot-on-first-chunk behaviour is returned as one consistent value.
- R7: Synchronous reset (rst high at a clock edge) aborts any burst. In the following cycle cpuReady is 1, and both strobes and cpuRvalid are 0. No further chunks are issued, so the target register does not commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuValid | input | 1 | Processor request valid |
| cpuReady | output | 1 | Bridge can accept a request |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | CPU_ADDR_W | Word address |
| cpuWdata | input | CPU_DATA_W | Write word |
| cpuRvalid | output | 1 | One-cycle response pulse |
| cpuRdata | output | CPU_DATA_W | Gathered read word |
| csrAddr | output | CPU_ADDR_W+log2(RATIO) | Chunk address |
| csrRstb | output | 1 | Chunk read strobe |
| csrWstb | output | 1 | Chunk write strobe |
| csrWdata | output | CSR_DATA_W | Chunk write data |
| csrRdata | input | CSR_DATA_W | Chunk read data, valid one cycle after its strobe |

## Verification
A chunk counter that is off by one shows up on csrAddr in the very next strobe cycle. It also shifts the returned lanes, so a read word comes back rotated or mixed with stale lanes in the response cycle. A sequencer that leaves a burst early or stays in it too long shows in the strobe count and in the response arriving away from the RATIO+2 mark. A register that snapshots on chunk 0 then returns a torn or uncommitted value. A missed reset clear shows up in the cycle after reset as ready low or a strobe still high.

// File: rtl/csr_width_bridge_pkg.sv
package csr_width_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_RESP  = 2'd3
  } bridgeState_t;

  typedef struct packed {
    logic load;     // latch address and write word on acceptance
    logic capture;  // store csrRdata into the lane selected by capIdx
  } bridgeStrobes_t;
endpackage

// File: rtl/csr_width_bridge_ctrl.sv
module csr_width_bridge_ctrl
  import csr_width_bridge_pkg::*;
#(
  parameter int RATIO = 4,
  parameter int IDX_W = $clog2(RATIO)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cpuValid,
  input  logic                 cpuWrite,
  output logic                 cpuReady,
  output logic                 cpuRvalid,
  output logic                 csrRstb,
  output logic                 csrWstb,
  output logic [IDX_W-1:0]     issueIdx,
  output logic [IDX_W-1:0]     capIdx,
  output bridgeStrobes_t       strobes
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RATIO - 1);

  bridgeState_t      state;
  logic [IDX_W-1:0]  chunkCnt;
  logic              opWrite;
  logic              capPend;
  logic [IDX_W-1:0]  capIdxQ;
  logic              accept;

  assign cpuReady  = (state == ST_IDLE) || (state == ST_RESP);
  assign accept    = cpuValid && cpuReady;
  assign cpuRvalid = (state == ST_RESP);
  assign csrRstb   = (state == ST_ISSUE) && !opWrite;
  assign csrWstb   = (state == ST_ISSUE) && opWrite;
  assign issueIdx  = chunkCnt;
  assign capIdx    = capIdxQ;

  always_comb begin
    strobes         = '0;
    strobes.load    = accept;
    strobes.capture = capPend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      chunkCnt <= '0;
      opWrite  <= 1'b0;
      capPend  <= 1'b0;
      capIdxQ  <= '0;
    end else begin
      // read data returns one cycle after its strobe
      capPend <= csrRstb;
      capIdxQ <= chunkCnt;
      case (state)
        ST_IDLE, ST_RESP: begin
          if (accept) begin
            state    <= ST_ISSUE;
            chunkCnt <= '0;
            opWrite  <= cpuWrite;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_ISSUE: begin
          if (chunkCnt == LAST_IDX) state <= ST_DRAIN;
          else chunkCnt <= chunkCnt + 1'b1;
        end
        default: state <= ST_RESP;
      endcase
    end
  end
endmodule

// File: rtl/csr_width_bridge_dp.sv
module csr_width_bridge_dp
  import csr_width_bridge_pkg::*;
#(
  parameter int CPU_ADDR_W = 8,
  parameter int CSR_DATA_W = 8,
  parameter int RATIO      = 4,
  parameter int IDX_W      = $clog2(RATIO),
  parameter int CPU_DATA_W = CSR_DATA_W * RATIO
) (
  input  logic                          clk,
  input  logic                          rst,
  input  bridgeStrobes_t                strobes,
  input  logic [IDX_W-1:0]              issueIdx,
  input  logic [IDX_W-1:0]              capIdx,
  input  logic [CPU_ADDR_W-1:0]         cpuAddr,
  input  logic [CPU_DATA_W-1:0]         cpuWdata,
  output logic [CPU_DATA_W-1:0]         cpuRdata,
  output logic [CPU_ADDR_W+IDX_W-1:0]   csrAddr,
  output logic [CSR_DATA_W-1:0]         csrWdata,
  input  logic [CSR_DATA_W-1:0]         csrRdata
);
  logic [CPU_ADDR_W-1:0] baseAddr;
  logic [CPU_DATA_W-1:0] wordQ;
  logic [CSR_DATA_W-1:0] writeLane [RATIO];
  logic [CSR_DATA_W-1:0] readLane  [RATIO];

  always_ff @(posedge clk) begin
    if (rst) begin
      baseAddr <= '0;
      wordQ    <= '0;
    end else if (strobes.load) begin
      baseAddr <= cpuAddr;
      wordQ    <= cpuWdata;
    end
  end

  for (genvar g = 0; g < RATIO; g++) begin : g_lane
    assign writeLane[g] = wordQ[g*CSR_DATA_W +: CSR_DATA_W];
    assign cpuRdata[g*CSR_DATA_W +: CSR_DATA_W] = readLane[g];
    always_ff @(posedge clk) begin
      if (rst) readLane[g] <= '0;
      else if (strobes.capture && capIdx == IDX_W'(g)) readLane[g] <= csrRdata;
    end
  end

  assign csrAddr  = {baseAddr, issueIdx};
  assign csrWdata = writeLane[issueIdx];
endmodule

// File: rtl/csr_width_bridge.sv
module csr_width_bridge
  import csr_width_bridge_pkg::*;
#(
  parameter int CPU_ADDR_W = 8,
  parameter int CPU_DATA_W = 32,
  parameter int CSR_DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cpuValid,
  output logic                              cpuReady,
  input  logic                              cpuWrite,
  input  logic [CPU_ADDR_W-1:0]             cpuAddr,
  input  logic [CPU_DATA_W-1:0]             cpuWdata,
  output logic                              cpuRvalid,
  output logic [CPU_DATA_W-1:0]             cpuRdata,
  output logic [CPU_ADDR_W+$clog2(CPU_DATA_W/CSR_DATA_W)-1:0] csrAddr,
  output logic                              csrRstb,
  output logic                              csrWstb,
  output logic [CSR_DATA_W-1:0]             csrWdata,
  input  logic [CSR_DATA_W-1:0]             csrRdata
);
  localparam int RATIO      = CPU_DATA_W / CSR_DATA_W;
  localparam int IDX_W      = $clog2(RATIO);
  localparam int CSR_ADDR_W = CPU_ADDR_W + IDX_W;

  bridgeStrobes_t   strobes;
  logic [IDX_W-1:0] issueIdx;
  logic [IDX_W-1:0] capIdx;

  csr_width_bridge_ctrl #(.RATIO(RATIO), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuReady(cpuReady), .cpuRvalid(cpuRvalid), .csrRstb(csrRstb),
    .csrWstb(csrWstb), .issueIdx(issueIdx), .capIdx(capIdx), .strobes(strobes)
  );

  csr_width_bridge_dp #(
    .CPU_ADDR_W(CPU_ADDR_W), .CSR_DATA_W(CSR_DATA_W), .RATIO(RATIO),
    .IDX_W(IDX_W), .CPU_DATA_W(CPU_DATA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .issueIdx(issueIdx),
    .capIdx(capIdx), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .csrAddr(csrAddr[CSR_ADDR_W-1:0]),
    .csrWdata(csrWdata), .csrRdata(csrRdata)
  );
endmodule

// File: rtl/csr_width_bridge_chk.sv
module csr_width_bridge_chk #(
  parameter int CSR_ADDR_W = 10,
  parameter int IDX_W      = 2,
  parameter int RATIO      = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cpuValid,
  input logic                  cpuReady,
  input logic                  cpuRvalid,
  input logic [CSR_ADDR_W-1:0] csrAddr,
  input logic                  csrRstb,
  input logic                  csrWstb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RATIO - 1);
  logic anyStb;
  assign anyStb = csrRstb || csrWstb;

  // R4: never both strobes
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !(csrRstb && csrWstb));

  // R4: no strobe while the processor side is ready
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    cpuReady |-> !anyStb);

  // R1: burst begins with chunk 0 right after acceptance
  assert_first_chunk_R1: assert property (@(posedge clk) disable iff (rst)
    (cpuValid && cpuReady) |=> (anyStb && csrAddr[IDX_W-1:0] == '0));

  // R1: ascending, back-to-back chunk addresses
  assert_ascending_R1: assert property (@(posedge clk) disable iff (rst)
    (anyStb && csrAddr[IDX_W-1:0] != LAST_IDX) |=>
      (anyStb && csrAddr == CSR_ADDR_W'($past(csrAddr) + 1'b1)));

  // R1: burst stops after the last chunk
  assert_burst_end_R1: assert property (@(posedge clk) disable iff (rst)
    (anyStb && csrAddr[IDX_W-1:0] == LAST_IDX) |=> !anyStb);

  // R5: ready falls after acceptance; response comes with ready
  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (cpuValid && cpuReady) |=> !cpuReady);
  assert_resp_ready_R5: assert property (@(posedge clk) disable iff (rst)
    cpuRvalid |-> cpuReady);
endmodule

bind csr_width_bridge csr_width_bridge_chk #(
  .CSR_ADDR_W(CSR_ADDR_W), .IDX_W(IDX_W), .RATIO(RATIO)
) u_chk (
  .clk(clk), .rst(rst), .cpuValid(cpuValid), .cpuReady(cpuReady),
  .cpuRvalid(cpuRvalid), .csrAddr(csrAddr), .csrRstb(csrRstb), .csrWstb(csrWstb)
);

// File: tb/csr_width_bridge_bench.sv
`timescale 1ns/1ps
module csr_width_bridge_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NW = 8;
  localparam int R  = DW / NW;
  localparam int IW = $clog2(R);
  localparam int NARROW_WORD = 3;   // 24-bit register
  localparam int CNT_WORD    = 7;   // read-only free-running counter

  logic clk = 0, rst = 1;
  logic cpuValid = 0, cpuWrite = 0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic cpuReady, cpuRvalid, csrRstb, csrWstb;
  logic [DW-1:0] cpuRdata;
  logic [AW+IW-1:0] csrAddr;
  logic [NW-1:0] csrWdata;
  logic [NW-1:0] csrRdata = '0;

  always #2 clk = ~clk;

  csr_width_bridge #(.CPU_ADDR_W(AW), .CPU_DATA_W(DW), .CSR_DATA_W(NW)) u_csr_width_bridge (
    .clk(clk), .rst(rst), .cpuValid(cpuValid), .cpuReady(cpuReady),
    .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRvalid(cpuRvalid), .cpuRdata(cpuRdata), .csrAddr(csrAddr),
    .csrRstb(csrRstb), .csrWstb(csrWstb), .csrWdata(csrWdata), .csrRdata(csrRdata)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- CSR-side register file model ----------------
  logic [DW-1:0] regMem  [1<<AW];
  logic [DW-1:0] snapReg [1<<AW];
  logic [DW-1:0] wAccum  [1<<AW];
  logic [DW-1:0] counter = '0;

  always @(posedge clk) begin
    int w, c;
    w = int'(csrAddr[AW+IW-1:IW]);
    c = int'(csrAddr[IW-1:0]);
    regMem[CNT_WORD] = counter;
    if (csrRstb) begin
      if (c == 0) snapReg[w] = regMem[w];
      csrRdata <= snapReg[w][c*NW +: NW];
    end
    if (csrWstb) begin
      wAccum[w][c*NW +: NW] = csrWdata;
      if (c == R-1 && w != CNT_WORD) begin
        if (w == NARROW_WORD) regMem[w] = {8'h00, wAccum[w][23:0]};
        else regMem[w] = wAccum[w];
      end
    end
    counter <= counter + 1;
  end

  // ---------------- strobe monitor ----------------
  bit inBurst = 0;
  bit expWrite = 0;
  logic [AW-1:0] expWord = '0;
  logic [DW-1:0] expWdata = '0;
  int stbCount = 0, orderErr = 0, dataErr = 0, idleErr = 0;
  logic [DW-1:0] cntSnap = '0;

  always @(negedge clk) begin
    if (!rst && (csrRstb || csrWstb)) begin
      if (!inBurst || (csrRstb && csrWstb)) idleErr++;
      if (csrAddr != {expWord, IW'(stbCount)} || csrWstb != expWrite) orderErr++;
      if (csrWstb && csrWdata != expWdata[stbCount*NW +: NW]) dataErr++;
      if (csrRstb && stbCount == 0) cntSnap = counter;
      stbCount++;
    end
  end

  logic [DW-1:0] refMem [8];

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd);
    int waited;
    int readyErr;
    check(cpuReady === 1'b1, "R5", "ready before request", cpuReady, 1);
    inBurst = 1; expWrite = wr; expWord = a; expWdata = d;
    stbCount = 0; orderErr = 0; dataErr = 0;
    cpuValid = 1; cpuWrite = wr; cpuAddr = a; cpuWdata = d;
    @(posedge clk);
    @(negedge clk);
    cpuValid = 0;
    waited = 1; readyErr = 0;
    while (!cpuRvalid && waited < 40) begin
      if (cpuReady) readyErr++;
      @(negedge clk);
      waited++;
    end
    rd = cpuRdata;
    inBurst = 0;
    check(waited == R+2, "R5", "response latency", waited, R+2);
    check(readyErr == 0, "R5", "ready low during burst", readyErr, 0);
    check(stbCount == R, "R1", "strobes per access", stbCount, R);
    check(orderErr == 0, "R1", "chunk order/address", orderErr, 0);
    if (wr) check(dataErr == 0, "R2", "write chunk data", dataErr, 0);
  endtask

  task automatic writeWord(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] dummy;
    access(1'b1, a, d, dummy);
    if (a == NARROW_WORD) refMem[a] = {8'h00, d[23:0]};
    else if (a != CNT_WORD) refMem[a] = d;
  endtask

  task automatic readWord(input logic [AW-1:0] a);
    logic [DW-1:0] got;
    access(1'b0, a, '0, got);
    if (a == CNT_WORD)
      check(got == cntSnap, "R6", "atomic counter snapshot", got, cntSnap);
    else
      check(got == refMem[a], "R3", "read word", got, refMem[a]);
  endtask

  initial begin
    int guard;
    for (int i = 0; i < (1<<AW); i++) begin
      regMem[i] = '0; snapReg[i] = '0; wAccum[i] = '0;
    end
    for (int i = 0; i < 8; i++) refMem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cpuReady === 1'b1, "R7", "reset ready", cpuReady, 1);
    check(csrRstb === 1'b0 && csrWstb === 1'b0, "R4", "reset strobes", {csrRstb, csrWstb}, 0);
    check(cpuRvalid === 1'b0, "R7", "reset rvalid", cpuRvalid, 0);
    rst = 0;
    @(negedge clk);

    // directed corners
    writeWord(0, 32'h1122_3344);
    readWord(0);
    writeWord(1, 32'hFFFF_FFFF);
    writeWord(2, 32'h0000_0000);
    readWord(1);
    readWord(2);
    writeWord(NARROW_WORD, 32'hDEAD_BEEF);   // narrow target: still four writes
    readWord(NARROW_WORD);
    readWord(CNT_WORD);                       // R6 snapshot of moving value
    writeWord(CNT_WORD, 32'h5555_AAAA);       // read-only target
    readWord(CNT_WORD);

    // reset in the middle of a write burst (R7)
    writeWord(4, 32'hA5A5_0F0F);
    inBurst = 1; expWrite = 1; expWord = 4; expWdata = 32'h0BAD_F00D; stbCount = 0;
    cpuValid = 1; cpuWrite = 1; cpuAddr = 4; cpuWdata = 32'h0BAD_F00D;
    @(posedge clk);
    @(negedge clk);
    cpuValid = 0;
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    inBurst = 0;
    check(cpuReady === 1'b1, "R7", "ready after abort", cpuReady, 1);
    check(csrRstb === 1'b0 && csrWstb === 1'b0, "R7", "strobes after abort", {csrRstb, csrWstb}, 0);
    check(cpuRvalid === 1'b0, "R7", "rvalid after abort", cpuRvalid, 0);
    @(negedge clk);
    readWord(4);   // old value: aborted burst must not commit (R7)

    // constrained random
    void'($urandom(32'd2024));
    for (int n = 0; n < 60; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 1) writeWord(a, $urandom());
      else readWord(a);
    end
    for (int i = 0; i < 7; i++) readWord(AW'(i));

    check(idleErr == 0, "R4", "strobes outside burst", idleErr, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule